// File: doc/BRIEF.md
# Branch history ring buffer

This block keeps a circular record of branch history words. Trace logic outside the block hands it one 64-bit word at a time on a push port. Each word lands in the slot the write pointer names, and the pointer then moves on by one. The slot the pointer names is always the oldest word, so it is the next one to be replaced. Software reads the record through an indexed port. The index counts back from the newest word: index 0 is the most recent push, index 1 the push before it, and so on.

Two commands come from software. A clear command wipes every entry. A read command returns one entry. Both commands first pass a permission stage. The first test is the hypervisor facility check. If that passes, the command is checked against problem state and a monitor-control access bit. A command that fails either test is faulted, and a cause code is stored in the matching cause register. Besides faults, a read also returns zero in three cases: the feature is absent, the index is N or larger, or the monitor alert (freeze) input is high.

Top module: `bhr_ring`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `rsp_vld`, `rsp_flt`, `rd_data`, `hv_cause` and `fs_cause` are all zero. Every entry reads back as zero after reset.
- R2: A read with index k (k < N) returns the word written by the (k+1)-th most recent push that was accepted. Index 0 is the newest word.
- R3: Each accepted push moves the write pointer forward by one, modulo N. After more than N pushes, the oldest words are replaced, and index N-1 holds the oldest word still kept.
- R4: A read that is not faulted returns zero when `alert_freeze` is high, when the index is N or larger, or when `feat_present` is low. In these cases `rsp_flt` stays 0.
- R5: An accepted clear sets every entry to zero and leaves the write pointer where it was. A push in the same cycle is dropped.
- R6: A command raised while `hv_capable`=1, `hv_state`=0 and `hv_fac_en`=0 gets `rsp_flt`=1 (hypervisor fault). A faulted read returns zero. A faulted clear leaves the entries unchanged.
- R7: A command that passes the hypervisor check, but is raised with `prob_state`=1 and `mon_acc_en`=0, gets `rsp_flt`=2 (problem-state fault), with the same effects as in R6.
- R8: A hypervisor fault writes HV_CAUSE into `hv_cause`. A problem-state fault writes FS_CAUSE into `fs_cause`. Each write replaces the old value, and the other register keeps its value.
- R9: The response comes one cycle after the command: `rsp_vld` is high exactly then, and `rsp_flt` and `rd_data` are zero in all other cycles. A read returns the contents as they stood before any push or clear at the same edge.
- R10: While `feat_present` is low, pushes and clears change nothing. This shows on reads once the feature is back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| feat_present | input | 1 | The history feature is implemented and enabled |
| hv_capable | input | 1 | The machine has a hypervisor state |
| hv_state | input | 1 | The current context is the hypervisor |
| hv_fac_en | input | 1 | The hypervisor grants this facility to guests |
| prob_state | input | 1 | The current context is problem (user) state |
| mon_acc_en | input | 1 | The monitor control bit that allows user access |
| alert_freeze | input | 1 | Monitor alert enabled; reads return zero |
| push_vld | input | 1 | Push a new history word |
| push_data | input | DW | Word to push |
| clr_req | input | 1 | Clear command |
| rd_req | input | 1 | Read command |
| rd_idx | input | KW | Read index, counted back from the newest |
| rsp_vld | output | 1 | Response to a command raised in the previous cycle |
| rsp_flt | output | 2 | 0 none, 1 hypervisor fault, 2 problem-state fault |
| rd_data | output | DW | Read result, zero when no read is answered |
| hv_cause | output | CW | Last hypervisor fault cause |
| fs_cause | output | CW | Last problem-state fault cause |

## Verification
The bench builds the block with N=8 and a 5-bit index. With these values the pointer wraps many times over a short run. Indices from 8 up to 31 exercise the out-of-range zero. The small depth also lets every slot be compared after each wrap. A behavioural model updates its own array and pointer every cycle. That model is used for the directed cases, including the same-edge pairings of read with push, read with clear, and clear with push, and for a randomized stretch that mixes all the gating inputs.

// File: rtl/bhr_pkg.sv
package bhr_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_HV   = 2'd1,
        FLT_PROB = 2'd2
    } flt_e;

    typedef struct packed {
        logic hv_capable;
        logic hv_state;
        logic hv_fac_en;
        logic prob_state;
        logic mon_acc_en;
    } priv_t;

    // The hypervisor check is evaluated first. The problem-state check
    // applies only when the hypervisor check passes.
    function automatic flt_e classify(input priv_t p);
        if (p.hv_capable && !p.hv_state && !p.hv_fac_en)
            return FLT_HV;
        if (p.prob_state && !p.mon_acc_en)
            return FLT_PROB;
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/bhr_gate.sv
module bhr_gate
    import bhr_pkg::*;
(
    input  priv_t p,
    input  logic  cmd,
    output flt_e  flt,
    output logic  go
);
    flt_e raw;

    always_comb begin
        raw = classify(p);
        flt = cmd ? raw : FLT_NONE;
        go  = cmd && (raw == FLT_NONE);
    end

endmodule

// File: rtl/bhr_store.sv
module bhr_store #(
    parameter int N  = 32,
    parameter int DW = 64,
    parameter int KW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          present,
    input  logic          push_vld,
    input  logic [DW-1:0] push_data,
    input  logic          clr_go,
    input  logic [KW-1:0] rd_idx,
    output logic [DW-1:0] rd_word
);
    localparam int PW = $clog2(N);
    localparam logic [KW:0] NLIM = (KW+1)'(N);

    logic [PW-1:0] wp;
    logic [DW-1:0] mem [N];
    logic          do_clr;
    logic          do_push;
    logic [PW-1:0] slot;
    logic          in_range;

    always_comb begin
        do_clr   = clr_go && present;
        do_push  = push_vld && present && !do_clr;
        slot     = wp - rd_idx[PW-1:0] - PW'(1);
        in_range = {1'b0, rd_idx} < NLIM;
        rd_word  = in_range ? mem[slot] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (do_clr) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (do_push) begin
            mem[wp] <= push_data;
            wp      <= wp + PW'(1);
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        do_push |=> wp == $past(wp) + PW'(1)); // R3
    AST_PTR_CLR_HOLD: assert property (@(posedge clk) disable iff (rst)
        do_clr |=> $stable(wp)); // R5
    AST_ABSENT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !present |=> $stable(wp)); // R10

endmodule

// File: rtl/bhr_cause.sv
module bhr_cause
    import bhr_pkg::*;
#(
    parameter int             CW       = 4,
    parameter logic [CW-1:0]  HV_CAUSE = CW'(3),
    parameter logic [CW-1:0]  FS_CAUSE = CW'(7)
) (
    input  logic          clk,
    input  logic          rst,
    input  flt_e          flt,
    output logic [CW-1:0] hv_cause,
    output logic [CW-1:0] fs_cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hv_cause <= '0;
            fs_cause <= '0;
        end else begin
            if (flt == FLT_HV)   hv_cause <= HV_CAUSE;
            if (flt == FLT_PROB) fs_cause <= FS_CAUSE;
        end
    end

    AST_HV_CAUSE: assert property (@(posedge clk) disable iff (rst)
        flt == FLT_HV |=> hv_cause == HV_CAUSE && $stable(fs_cause)); // R8
    AST_FS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        flt == FLT_PROB |=> fs_cause == FS_CAUSE && $stable(hv_cause)); // R8

endmodule

// File: rtl/bhr_ring.sv
module bhr_ring
    import bhr_pkg::*;
#(
    parameter int            N        = 32,
    parameter int            DW       = 64,
    parameter int            KW       = 8,
    parameter int            CW       = 4,
    parameter logic [CW-1:0] HV_CAUSE = CW'(3),
    parameter logic [CW-1:0] FS_CAUSE = CW'(7)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          feat_present,
    input  logic          hv_capable,
    input  logic          hv_state,
    input  logic          hv_fac_en,
    input  logic          prob_state,
    input  logic          mon_acc_en,
    input  logic          alert_freeze,
    input  logic          push_vld,
    input  logic [DW-1:0] push_data,
    input  logic          clr_req,
    input  logic          rd_req,
    input  logic [KW-1:0] rd_idx,
    output logic          rsp_vld,
    output logic [1:0]    rsp_flt,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] hv_cause,
    output logic [CW-1:0] fs_cause
);
    priv_t         priv;
    logic          cmd;
    flt_e          flt;
    logic          go;
    logic [DW-1:0] word;
    logic          rd_ok;

    assign priv = '{hv_capable: hv_capable, hv_state: hv_state,
                    hv_fac_en: hv_fac_en, prob_state: prob_state,
                    mon_acc_en: mon_acc_en};
    assign cmd  = rd_req || clr_req;

    bhr_gate i_gate (
        .p   (priv),
        .cmd (cmd),
        .flt (flt),
        .go  (go)
    );

    bhr_store #(.N(N), .DW(DW), .KW(KW)) i_store (
        .clk       (clk),
        .rst       (rst),
        .present   (feat_present),
        .push_vld  (push_vld),
        .push_data (push_data),
        .clr_go    (go && clr_req),
        .rd_idx    (rd_idx),
        .rd_word   (word)
    );

    bhr_cause #(.CW(CW), .HV_CAUSE(HV_CAUSE), .FS_CAUSE(FS_CAUSE)) i_cause (
        .clk      (clk),
        .rst      (rst),
        .flt      (flt),
        .hv_cause (hv_cause),
        .fs_cause (fs_cause)
    );

    assign rd_ok = go && rd_req && feat_present && !alert_freeze;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld <= 1'b0;
            rsp_flt <= 2'd0;
            rd_data <= '0;
        end else begin
            rsp_vld <= cmd;
            rsp_flt <= flt;
            rd_data <= rd_ok ? word : '0;
        end
    end

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        cmd |=> rsp_vld); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cmd |=> !rsp_vld && rsp_flt == 2'd0 && rd_data == '0); // R9
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_flt != 2'd0) |-> rd_data == '0); // R6
    AST_FREEZE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && alert_freeze) |=> rd_data == '0); // R4
    AST_HV_FIRST: assert property (@(posedge clk) disable iff (rst)
        (cmd && hv_capable && !hv_state && !hv_fac_en) |=> rsp_flt == 2'd1); // R6

endmodule

// File: tb/test_bhr_ring.sv
module test_bhr_ring;
    localparam int N  = 8;
    localparam int DW = 64;
    localparam int KW = 5;
    localparam logic [3:0] HVC = 4'h3;
    localparam logic [3:0] FSC = 4'h7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic feat_present = 1'b1, hv_capable = 1'b1, hv_state = 1'b1, hv_fac_en = 1'b0;
    logic prob_state = 1'b0, mon_acc_en = 1'b0, alert_freeze = 1'b0;
    logic push_vld = 1'b0, clr_req = 1'b0, rd_req = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic [KW-1:0] rd_idx = '0;
    logic          rsp_vld;
    logic [1:0]    rsp_flt;
    logic [DW-1:0] rd_data;
    logic [3:0]    hv_cause, fs_cause;

    always #2 clk = ~clk;

    bhr_ring #(.N(N), .DW(DW), .KW(KW), .CW(4), .HV_CAUSE(HVC), .FS_CAUSE(FSC)) i_bhr_ring (
        .clk(clk), .rst(rst), .feat_present(feat_present), .hv_capable(hv_capable),
        .hv_state(hv_state), .hv_fac_en(hv_fac_en), .prob_state(prob_state),
        .mon_acc_en(mon_acc_en), .alert_freeze(alert_freeze), .push_vld(push_vld),
        .push_data(push_data), .clr_req(clr_req), .rd_req(rd_req), .rd_idx(rd_idx),
        .rsp_vld(rsp_vld), .rsp_flt(rsp_flt), .rd_data(rd_data),
        .hv_cause(hv_cause), .fs_cause(fs_cause)
    );

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] mdl [N];
    int wp = 0;
    logic [3:0] m_hv = '0, m_fs = '0;
    int cyc_cnt = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // Model of one clock: expectation from current inputs, then compare after the edge.
    task automatic step(input string tag);
        int kind;
        logic [DW-1:0] ed;
        logic cmd;
        cmd  = rd_req || clr_req;
        kind = 0;
        if (cmd) begin
            if (hv_capable && !hv_state && !hv_fac_en) kind = 1;
            else if (prob_state && !mon_acc_en)        kind = 2;
        end
        ed = '0;
        if (rd_req && kind == 0 && feat_present && !alert_freeze && int'(rd_idx) < N)
            ed = mdl[((wp - int'(rd_idx) - 1) % N + N) % N];
        if (clr_req && kind == 0 && feat_present) begin
            for (int i = 0; i < N; i++) mdl[i] = '0;
        end else if (push_vld && feat_present) begin
            mdl[wp] = push_data;
            wp = (wp + 1) % N;
        end
        if (kind == 1) m_hv = HVC;
        if (kind == 2) m_fs = FSC;
        @(posedge clk);
        #1;
        chk(tag, "rsp_vld", 64'(rsp_vld), 64'(cmd));
        chk(tag, "rsp_flt", 64'(rsp_flt), 64'(kind));
        chk(tag, "rd_data", rd_data, ed);
        chk(tag, "hv_cause", 64'(hv_cause), 64'(m_hv));
        chk(tag, "fs_cause", 64'(fs_cause), 64'(m_fs));
    endtask

    task automatic idle();
        push_vld = 0; clr_req = 0; rd_req = 0;
    endtask

    task automatic push(input string tag, input logic [DW-1:0] d);
        idle(); push_vld = 1; push_data = d; step(tag); idle();
    endtask

    task automatic rd(input string tag, input int k);
        idle(); rd_req = 1; rd_idx = KW'(k); step(tag); idle();
    endtask

    task automatic clr(input string tag);
        idle(); clr_req = 1; step(tag); idle();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "rsp_vld in reset", 64'(rsp_vld), 0);
        chk("R1", "rd_data in reset", rd_data, 0);
        rst = 0;
        step("R1");
        for (int k = 0; k < N; k++) rd("R1", k);

        // fill partly, then read every index
        for (int i = 0; i < 5; i++) push("R2", 64'hA000 + 64'(i));
        for (int k = 0; k < N; k++) rd("R2", k);

        // wrap the pointer more than once
        for (int i = 0; i < 2*N + 3; i++) push("R3", 64'hB0B0_0000 + 64'(i));
        for (int k = 0; k < N; k++) rd("R3", k);

        // out-of-range, freeze, absent feature
        for (int k = N; k < 32; k += 5) rd("R4", k);
        alert_freeze = 1; rd("R4", 0); rd("R4", 3); alert_freeze = 0;
        feat_present = 0; rd("R4", 0); feat_present = 1;

        // feature absent: push and clear ignored
        feat_present = 0;
        push("R10", 64'hDEAD); clr("R10");
        feat_present = 1;
        for (int k = 0; k < N; k++) rd("R10", k);

        // read with a same-edge push and with a same-edge clear
        idle(); rd_req = 1; rd_idx = 0; push_vld = 1; push_data = 64'hC1; step("R9"); idle();
        rd("R9", 0);
        idle(); rd_req = 1; rd_idx = 1; clr_req = 1; step("R9"); idle();
        rd("R9", 0);

        // clear wins over push
        push("R5", 64'h11); push("R5", 64'h22);
        idle(); clr_req = 1; push_vld = 1; push_data = 64'h33; step("R5"); idle();
        for (int k = 0; k < N; k++) rd("R5", k);
        push("R5", 64'h44); rd("R5", 0); rd("R5", 1);

        // hypervisor fault on read and on clear
        hv_state = 0; hv_fac_en = 0;
        rd("R6", 0); clr("R6");
        hv_fac_en = 1; rd("R6", 0);
        hv_state = 1; hv_fac_en = 0;

        // problem-state fault, and its pass case
        prob_state = 1; mon_acc_en = 0;
        rd("R7", 0); clr("R7");
        mon_acc_en = 1; rd("R7", 0);
        prob_state = 0; mon_acc_en = 0;

        // cause registers replace, independently
        hv_state = 0; prob_state = 1; rd("R8", 0);
        hv_state = 1; rd("R8", 0);
        hv_capable = 0; hv_state = 0; rd("R8", 0);
        hv_capable = 1; hv_state = 1; prob_state = 0;

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            push_vld     = ($urandom % 2) == 0;
            push_data    = {$urandom, $urandom};
            clr_req      = ($urandom % 17) == 0;
            rd_req       = ($urandom % 3) == 0;
            rd_idx       = KW'($urandom % 12);
            feat_present = ($urandom % 9) != 0;
            alert_freeze = ($urandom % 7) == 0;
            hv_state     = ($urandom % 5) != 0;
            hv_fac_en    = ($urandom % 2) == 0;
            prob_state   = ($urandom % 4) == 0;
            mon_acc_en   = ($urandom % 2) == 0;
            step("R2");
        end
        idle();
        finish_run();
    end

endmodule